// File: doc/BRIEF.md
# Load Ordering Queue

This block holds the in-flight loads of an out-of-order core in a circular buffer, in program order. Each load arrives with a sequence number and an address and is written at the tail. It also records the store-queue tail position of that moment, or an invalid marker when no stores are outstanding. Entries leave from the head when the core retires up to a given sequence number. On a mispredict, a squash removes the younger entries from the tail end.

When a store executes, the core probes the queue with the store's address and the load index that the store captured when it was allocated. The block looks at the loads from that index to the tail and picks the oldest one whose address lies in the same coarse block as the store. That load is held as the ordering violator until the core acknowledges it. A separate marker for a stalled load is dropped when a squash reaches back past that load.

Only one queue operation is accepted per clock. Squash has the highest priority, then commit, then allocate, then probe. Lower-priority requests in the same cycle are dropped.

Top module: `lq_order_queue`

## Requirements
- R1: An accepted allocate writes the entry at `lq_tail`, advances the tail with wrap from DEPTH-1 to 0, and adds one to `lq_count`. `lq_full` is high exactly when `lq_count` equals DEPTH, and an allocate while full changes nothing.
- R2: An entry records `alloc_sq_tail` with its valid bit set when `alloc_sq_empty` is low. When `alloc_sq_empty` is high, the valid bit is clear. For the oldest entry these appear on `head_tag` and `head_tag_valid`.
- R3: A commit removes head entries one after another, in one cycle, for as long as the queue is non-empty and the head's sequence number is less than or equal to `commit_seq`. `head_seq` then shows the new oldest entry.
- R4: A squash walks backward from the newest entry and removes every entry whose sequence number is strictly greater than `squash_seq`. It stops at the first entry that is not greater, and `lq_tail` moves back over each removed entry.
- R5: A probe considers only the occupied entries from `probe_lidx` up to, but not including, the tail. An entry matches when its address bits above bit BLOCK_SHIFT-1 (default 8, so 256-byte blocks) equal those of `probe_addr`.
- R6: On a match, the oldest matching entry in the probed range is latched: `viol_valid` rises, `viol_idx` and `viol_seq` give its slot and sequence number, and `probe_fault` pulses for one cycle. Both outputs change in the cycle after the probe.
- R7: While a violator is held, a probe performs no scan and leaves `viol_idx`, `viol_seq` and `probe_fault` unchanged.
- R8: `viol_ack` clears a held violator in the next cycle.
- R9: `hold_set` sets `hold_flag` and records `hold_seq`. A squash whose `squash_seq` is smaller than the recorded number clears the flag, and this takes priority over a set in the same cycle.
- R10: A squash in the same cycle as a commit or allocate blocks them both. A commit blocks an allocate, and any of the three blocks a probe.
- R11: After reset the queue is empty, the tail is 0, and `viol_valid`, `probe_fault` and `hold_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_addr | input | ADDR_W | Address of the new load |
| alloc_sq_empty | input | 1 | No stores outstanding at allocation |
| alloc_sq_tail | input | SQ_IDX_W | Store-queue tail at allocation |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Retire loads up to this sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Remove loads younger than this number |
| probe_valid | input | 1 | Executing-store probe |
| probe_addr | input | ADDR_W | Store address |
| probe_lidx | input | IDX_W | First load slot younger than the store |
| viol_ack | input | 1 | Read of the violator; clears it |
| hold_set | input | 1 | Record a stalled load |
| hold_seq | input | SEQ_W | Sequence number of the stalled load |
| lq_count | output | CNT_W | Occupied entries |
| lq_full | output | 1 | Queue full |
| lq_tail | output | IDX_W | Slot the next load will take |
| head_seq | output | SEQ_W | Sequence number of the oldest load |
| head_tag_valid | output | 1 | Oldest load has a store-queue tag |
| head_tag | output | SQ_IDX_W | Store-queue tag of the oldest load |
| viol_valid | output | 1 | A violator is held |
| viol_idx | output | IDX_W | Slot of the violator |
| viol_seq | output | SEQ_W | Sequence number of the violator |
| probe_fault | output | 1 | One-cycle pulse: the last probe found a violator |
| hold_flag | output | 1 | A stalled load is recorded |

## Verification
The probe is run in three kinds of case. In the first, the only same-block load lies before the probe index, so it has to be skipped. In the second, two younger loads share the store's block, and the result separates the oldest from the newer one. In the third, a probe arrives while a violator is already held, so any rescan would show. A squash, a commit and an allocate are issued in the same cycle to show that only the squash takes effect. Long random runs then mix allocates with partial commits, squashes that stop part way, probes from every offset, and addresses drawn from four blocks. These runs exercise tail wrap and the full queue, and each cycle is compared with a sequential walking model.

// File: rtl/lq_pkg.sv
package lq_pkg;

  // Circular index helpers, operands already in range [0, depth)
  function automatic int ring_add(input int a, input int b, input int depth);
    int s;
    s = a + b;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  function automatic int ring_sub(input int a, input int b, input int depth);
    int d;
    d = a - b;
    if (d < 0) d = d + depth;
    return d;
  endfunction

endpackage

// File: rtl/lq_lead_run.sv
// Length of the unbroken run of set bits starting at position 0.
module lq_lead_run #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [N-1:0]  hits,
  output logic [CW-1:0] len
);
  always_comb begin
    logic run;
    run = 1'b1;
    len = '0;
    for (int k = 0; k < N; k++) begin
      if (run && hits[k]) len = len + CW'(1);
      else                run = 1'b0;
    end
  end
endmodule

// File: rtl/lq_first_hit.sv
// Lowest set position of a hit vector.
module lq_first_hit #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  hits,
  output logic          found,
  output logic [IW-1:0] off
);
  always_comb begin
    found = 1'b0;
    off   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hits[k]) begin
        found = 1'b1;
        off   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/lq_order_queue.sv
module lq_order_queue import lq_pkg::*; #(
  parameter int DEPTH       = 8,
  parameter int SEQ_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int SQ_IDX_W    = 3,
  parameter int BLOCK_SHIFT = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                alloc_valid,
  input  logic [SEQ_W-1:0]    alloc_seq,
  input  logic [ADDR_W-1:0]   alloc_addr,
  input  logic                alloc_sq_empty,
  input  logic [SQ_IDX_W-1:0] alloc_sq_tail,
  input  logic                commit_valid,
  input  logic [SEQ_W-1:0]    commit_seq,
  input  logic                squash_valid,
  input  logic [SEQ_W-1:0]    squash_seq,
  input  logic                probe_valid,
  input  logic [ADDR_W-1:0]   probe_addr,
  input  logic [IDX_W-1:0]    probe_lidx,
  input  logic                viol_ack,
  input  logic                hold_set,
  input  logic [SEQ_W-1:0]    hold_seq,
  output logic [CNT_W-1:0]    lq_count,
  output logic                lq_full,
  output logic [IDX_W-1:0]    lq_tail,
  output logic [SEQ_W-1:0]    head_seq,
  output logic                head_tag_valid,
  output logic [SQ_IDX_W-1:0] head_tag,
  output logic                viol_valid,
  output logic [IDX_W-1:0]    viol_idx,
  output logic [SEQ_W-1:0]    viol_seq,
  output logic                probe_fault,
  output logic                hold_flag
);

  localparam int BLK_W = ADDR_W - BLOCK_SHIFT;

  // Entry storage: every slot is read in parallel by the scans
  logic [SEQ_W-1:0]    seq_q  [DEPTH];
  logic [BLK_W-1:0]    blk_q  [DEPTH];
  logic [SQ_IDX_W-1:0] tag_q  [DEPTH];
  logic [DEPTH-1:0]    tagv_q;

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             hold_q;
  logic [SEQ_W-1:0] hold_seq_q;

  // Slot positions ordered by age, oldest first / newest first
  logic [IDX_W-1:0] fwd_pos [DEPTH];
  logic [IDX_W-1:0] bwd_pos [DEPTH];
  int               lidx_off;

  always_comb begin
    lidx_off = ring_sub(int'(probe_lidx), int'(head_q), DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      fwd_pos[k] = IDX_W'(ring_add(int'(head_q), k, DEPTH));
      bwd_pos[k] = IDX_W'(ring_sub(int'(tail_q), k + 1, DEPTH));
    end
  end

  logic [DEPTH-1:0] commit_hits, squash_hits, probe_hits;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic occupied;
    assign occupied       = g < int'(count_q);
    assign commit_hits[g] = occupied && (seq_q[fwd_pos[g]] <= commit_seq);
    assign squash_hits[g] = occupied && (seq_q[bwd_pos[g]] > squash_seq);
    assign probe_hits[g]  = occupied && (g >= lidx_off) &&
                            (blk_q[fwd_pos[g]] == probe_addr[ADDR_W-1:BLOCK_SHIFT]);
  end

  logic [CNT_W-1:0] commit_len, squash_len;
  logic             probe_found;
  logic [IDX_W-1:0] probe_off;

  lq_lead_run #(.N(DEPTH), .CW(CNT_W)) u_commit_run (
    .hits (commit_hits),
    .len  (commit_len)
  );

  lq_lead_run #(.N(DEPTH), .CW(CNT_W)) u_squash_run (
    .hits (squash_hits),
    .len  (squash_len)
  );

  lq_first_hit #(.N(DEPTH), .IW(IDX_W)) u_probe_first (
    .hits  (probe_hits),
    .found (probe_found),
    .off   (probe_off)
  );

  // One operation per cycle: squash > commit > allocate > probe
  logic full_w, do_alloc, do_probe;
  logic [IDX_W-1:0] hit_pos;
  assign full_w   = count_q == CNT_W'(DEPTH);
  assign do_alloc = alloc_valid && !squash_valid && !commit_valid && !full_w;
  assign do_probe = probe_valid && !squash_valid && !commit_valid && !alloc_valid && !viol_valid;
  assign hit_pos  = fwd_pos[probe_off];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (squash_valid) begin
      tail_q  <= IDX_W'(ring_sub(int'(tail_q), int'(squash_len), DEPTH));
      count_q <= count_q - squash_len;
    end else if (commit_valid) begin
      head_q  <= IDX_W'(ring_add(int'(head_q), int'(commit_len), DEPTH));
      count_q <= count_q - commit_len;
    end else if (do_alloc) begin
      tail_q  <= IDX_W'(ring_add(int'(tail_q), 1, DEPTH));
      count_q <= count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      seq_q[tail_q]  <= alloc_seq;
      blk_q[tail_q]  <= alloc_addr[ADDR_W-1:BLOCK_SHIFT];
      tag_q[tail_q]  <= alloc_sq_tail;
      tagv_q[tail_q] <= !alloc_sq_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_valid  <= 1'b0;
      viol_idx    <= '0;
      viol_seq    <= '0;
      probe_fault <= 1'b0;
    end else begin
      probe_fault <= do_probe && probe_found;
      if (do_probe && probe_found) begin
        viol_valid <= 1'b1;
        viol_idx   <= hit_pos;
        viol_seq   <= seq_q[hit_pos];
      end else if (viol_ack) begin
        viol_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= 1'b0;
      hold_seq_q <= '0;
    end else if (squash_valid && hold_q && (squash_seq < hold_seq_q)) begin
      hold_q     <= 1'b0;
    end else if (hold_set) begin
      hold_q     <= 1'b1;
      hold_seq_q <= hold_seq;
    end
  end

  assign lq_count       = count_q;
  assign lq_full        = full_w;
  assign lq_tail        = tail_q;
  assign head_seq       = seq_q[head_q];
  assign head_tag_valid = (count_q != '0) && tagv_q[head_q];
  assign head_tag       = tag_q[head_q];
  assign hold_flag      = hold_q;

endmodule

// File: rtl/lq_order_check.sv
module lq_order_check #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             commit_valid,
  input logic             squash_valid,
  input logic [SEQ_W-1:0] squash_seq,
  input logic             viol_ack,
  input logic [CNT_W-1:0] lq_count,
  input logic             lq_full,
  input logic [IDX_W-1:0] lq_tail,
  input logic [IDX_W-1:0] head_q,
  input logic             viol_valid,
  input logic [IDX_W-1:0] viol_idx,
  input logic [SEQ_W-1:0] viol_seq,
  input logic             probe_fault,
  input logic             hold_flag,
  input logic [SEQ_W-1:0] hold_seq_q
);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    int'(lq_count) <= DEPTH);

  assert_full_refuse_R1: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !squash_valid && !commit_valid && lq_full)
      |=> ($stable(lq_tail) && $stable(lq_count)));

  assert_commit_keeps_tail_R3: assert property (@(posedge clk) disable iff (rst)
    (commit_valid && !squash_valid) |=> $stable(lq_tail));

  assert_squash_blocks_commit_R10: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> $stable(head_q));

  assert_fault_has_violator_R6: assert property (@(posedge clk) disable iff (rst)
    probe_fault |-> viol_valid);

  assert_violator_held_R7: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && !viol_ack) |=> (viol_valid && $stable(viol_idx) && $stable(viol_seq)));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_ack) |=> !viol_valid);

  assert_hold_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    (squash_valid && hold_flag && (squash_seq < hold_seq_q)) |=> !hold_flag);

endmodule

bind lq_order_queue lq_order_check #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_order_check (
  .clk          (clk),
  .rst          (rst),
  .alloc_valid  (alloc_valid),
  .commit_valid (commit_valid),
  .squash_valid (squash_valid),
  .squash_seq   (squash_seq),
  .viol_ack     (viol_ack),
  .lq_count     (lq_count),
  .lq_full      (lq_full),
  .lq_tail      (lq_tail),
  .head_q       (head_q),
  .viol_valid   (viol_valid),
  .viol_idx     (viol_idx),
  .viol_seq     (viol_seq),
  .probe_fault  (probe_fault),
  .hold_flag    (hold_flag),
  .hold_seq_q   (hold_seq_q)
);

// File: tb/test_lq_order_queue.sv
module test_lq_order_queue;
  localparam int CLK_PERIOD  = 10;
  localparam int DEPTH       = 8;
  localparam int SEQ_W       = 16;
  localparam int ADDR_W      = 32;
  localparam int SQ_IDX_W    = 3;
  localparam int BLOCK_SHIFT = 8;
  localparam int IDX_W       = $clog2(DEPTH);
  localparam int CNT_W       = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic                alloc_valid = 0, alloc_sq_empty = 0;
  logic [SEQ_W-1:0]    alloc_seq = '0, commit_seq = '0, squash_seq = '0, hold_seq = '0;
  logic [ADDR_W-1:0]   alloc_addr = '0, probe_addr = '0;
  logic [SQ_IDX_W-1:0] alloc_sq_tail = '0;
  logic                commit_valid = 0, squash_valid = 0, probe_valid = 0;
  logic [IDX_W-1:0]    probe_lidx = '0;
  logic                viol_ack = 0, hold_set = 0;
  logic [CNT_W-1:0]    lq_count;
  logic                lq_full, head_tag_valid, viol_valid, probe_fault, hold_flag;
  logic [IDX_W-1:0]    lq_tail, viol_idx;
  logic [SEQ_W-1:0]    head_seq, viol_seq;
  logic [SQ_IDX_W-1:0] head_tag;

  lq_order_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
                   .SQ_IDX_W(SQ_IDX_W), .BLOCK_SHIFT(BLOCK_SHIFT)) i_lq_order_queue (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_addr(alloc_addr),
    .alloc_sq_empty(alloc_sq_empty), .alloc_sq_tail(alloc_sq_tail),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_lidx(probe_lidx),
    .viol_ack(viol_ack), .hold_set(hold_set), .hold_seq(hold_seq),
    .lq_count(lq_count), .lq_full(lq_full), .lq_tail(lq_tail),
    .head_seq(head_seq), .head_tag_valid(head_tag_valid), .head_tag(head_tag),
    .viol_valid(viol_valid), .viol_idx(viol_idx), .viol_seq(viol_seq),
    .probe_fault(probe_fault), .hold_flag(hold_flag)
  );

  int n_checks = 0;
  int n_err    = 0;

  // Reference model state
  int mseq [DEPTH];
  int mblk [DEPTH];
  int mtag [DEPTH];
  bit mtagv[DEPTH];
  int mhead = 0, mtail = 0, mcnt = 0;
  bit mviol = 0, mfault = 0, mhold = 0;
  int mvidx = 0, mvseq = 0, mhseq = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rinc(input int i);
    return (i + 1) % DEPTH;
  endfunction

  function automatic int rdec(input int i);
    return (i + DEPTH - 1) % DEPTH;
  endfunction

  task automatic model_apply();
    bit latched;
    latched = 0;
    mfault  = 0;
    if (squash_valid) begin
      while (mcnt > 0 && mseq[rdec(mtail)] > int'(squash_seq)) begin
        mtail = rdec(mtail);
        mcnt--;
      end
    end else if (commit_valid) begin
      while (mcnt > 0 && mseq[mhead] <= int'(commit_seq)) begin
        mhead = rinc(mhead);
        mcnt--;
      end
    end else if (alloc_valid) begin
      if (mcnt < DEPTH) begin
        mseq[mtail]  = int'(alloc_seq);
        mblk[mtail]  = int'(alloc_addr >> BLOCK_SHIFT);
        mtag[mtail]  = int'(alloc_sq_tail);
        mtagv[mtail] = !alloc_sq_empty;
        mtail = rinc(mtail);
        mcnt++;
      end
    end else if (probe_valid && !mviol) begin
      int start;
      start = (int'(probe_lidx) - mhead + DEPTH) % DEPTH;
      for (int k = start; k < mcnt; k++) begin
        int p;
        p = (mhead + k) % DEPTH;
        if (mblk[p] == int'(probe_addr >> BLOCK_SHIFT)) begin
          mviol = 1; mvidx = p; mvseq = mseq[p]; mfault = 1; latched = 1;
          break;
        end
      end
    end
    if (viol_ack && !latched) mviol = 0;
    if (squash_valid && mhold && int'(squash_seq) < mhseq) mhold = 0;
    else if (hold_set) begin mhold = 1; mhseq = int'(hold_seq); end
  endtask

  task automatic clear_inputs();
    alloc_valid = 0; commit_valid = 0; squash_valid = 0; probe_valid = 0;
    viol_ack = 0; hold_set = 0;
  endtask

  task automatic compare_all();
    chk("R1", "count", lq_count, mcnt);
    chk("R1", "tail", lq_tail, mtail);
    chk("R1", "full", lq_full, mcnt == DEPTH);
    if (mcnt > 0) begin
      chk("R3", "head_seq", head_seq, mseq[mhead]);
      chk("R2", "head_tag_valid", head_tag_valid, mtagv[mhead]);
      if (mtagv[mhead]) chk("R2", "head_tag", head_tag, mtag[mhead]);
    end
    chk("R6", "viol_valid", viol_valid, mviol);
    if (mviol) begin
      chk("R6", "viol_idx", viol_idx, mvidx);
      chk("R6", "viol_seq", viol_seq, mvseq);
    end
    chk("R6", "probe_fault", probe_fault, mfault);
    chk("R9", "hold_flag", hold_flag, mhold);
  endtask

  // Inputs are set at a falling edge; outputs compared at the next falling edge
  task automatic step();
    model_apply();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    clear_inputs();
  endtask

  task automatic do_alloc(input int s, input int addr, input bit empty, input int tag);
    alloc_valid = 1; alloc_seq = SEQ_W'(s); alloc_addr = ADDR_W'(addr);
    alloc_sq_empty = empty; alloc_sq_tail = SQ_IDX_W'(tag);
    step();
  endtask

  task automatic do_probe(input int lidx, input int addr);
    probe_valid = 1; probe_lidx = IDX_W'(lidx); probe_addr = ADDR_W'(addr);
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    int next_seq;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R11: reset state
    chk("R11", "count", lq_count, 0);
    chk("R11", "tail", lq_tail, 0);
    chk("R11", "viol_valid", viol_valid, 0);
    chk("R11", "probe_fault", probe_fault, 0);
    chk("R11", "hold_flag", hold_flag, 0);

    // R1/R2: fill; slot i gets seq i+1, block i (slot 6 shares block 5)
    for (int i = 0; i < DEPTH; i++)
      do_alloc(i + 1, (i == 6) ? ((5 << 8) | 'hF0) : ((i << 8) | 'h10), i == 0, i);
    chk("R2", "head_tag_valid empty sq", head_tag_valid, 0);
    chk("R1", "full", lq_full, 1);
    do_alloc(50, 'h700, 0, 1);
    chk("R1", "count after refused alloc", lq_count, DEPTH);
    chk("R1", "tail wrapped", lq_tail, 0);

    // R5: block 3 only before the probe index -> no match
    do_probe(6, (3 << 8) | 'h44);
    chk("R5", "no match before index", viol_valid, 0);
    // R5/R6: block 5 at slots 5 and 6 -> oldest (slot 5) latched
    do_probe(2, (5 << 8) | 'h33);
    chk("R5", "viol_idx", viol_idx, 5);
    chk("R6", "viol_seq", viol_seq, 6);
    chk("R6", "probe_fault", probe_fault, 1);
    // R7: held violator blocks a new scan
    do_probe(0, 'h010);
    chk("R7", "viol_idx kept", viol_idx, 5);
    chk("R7", "no new fault", probe_fault, 0);
    // R8: acknowledge clears
    viol_ack = 1; step();
    chk("R8", "viol cleared", viol_valid, 0);

    // R10/R4: squash wins over commit and allocate
    squash_valid = 1; squash_seq = 4; commit_valid = 1; commit_seq = 8;
    alloc_valid = 1; alloc_seq = 60; step();
    chk("R10", "count after squash", lq_count, 4);
    chk("R10", "head_seq unchanged", head_seq, 1);
    chk("R4", "tail moved back", lq_tail, 4);
    squash_valid = 1; squash_seq = 10; step();
    chk("R4", "nothing younger", lq_count, 4);
    // R3: partial commit
    commit_valid = 1; commit_seq = 2; step();
    chk("R3", "count after commit", lq_count, 2);
    chk("R3", "new head", head_seq, 3);
    // R9: hold flag
    hold_set = 1; hold_seq = 20; step();
    squash_valid = 1; squash_seq = 25; step();
    chk("R9", "not cleared by larger", hold_flag, 1);
    squash_valid = 1; squash_seq = 15; hold_set = 1; hold_seq = 30; step();
    chk("R9", "cleared by smaller", hold_flag, 0);

    // Random mix, checked every cycle against the model
    next_seq = 100;
    for (int it = 0; it < 4000; it++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 38) begin
        alloc_valid = 1; alloc_seq = SEQ_W'(next_seq); next_seq++;
        alloc_addr = ADDR_W'((($urandom % 4) << 8) | ($urandom % 256));
        alloc_sq_empty = ($urandom % 4) == 0; alloc_sq_tail = SQ_IDX_W'($urandom);
      end else if (r < 52) begin
        commit_valid = 1; commit_seq = SEQ_W'(next_seq - 12 + int'($urandom % 8));
      end else if (r < 60) begin
        squash_valid = 1; squash_seq = SEQ_W'(next_seq - 1 - int'($urandom % 8));
      end else if (r < 92) begin
        probe_valid = 1;
        probe_lidx = IDX_W'((mhead + int'($urandom % (mcnt + 1))) % DEPTH);
        probe_addr = ADDR_W'((($urandom % 4) << 8) | ($urandom % 256));
      end
      if (($urandom % 10) == 0) begin
        commit_valid = 1; commit_seq = SEQ_W'(next_seq - 10);
      end
      if (($urandom % 3) == 0) viol_ack = 1;
      if (($urandom % 12) == 0) begin
        hold_set = 1; hold_seq = SEQ_W'(next_seq - int'($urandom % 6));
      end
      step();
    end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule